// File: doc/BRIEF.md
# EPP Address/Data Cycle Engine

This block sits behind a parallel port's host register file. It runs enhanced-parallel-port address and data transfers on the peripheral side. It holds the port control register and a sticky timeout flag. It also serves status reads, in which bit 0 of the status byte from outside the block is replaced by that flag.

A host access to the address offset (3) or the data offset (4) is checked against the control register. The direction, select-in, initialise, auto-linefeed and strobe bits, masked with 0x2F, must equal 0x04 for a write and 0x24 for a read. When they match, the block runs one peripheral handshake per byte. A data access may be 1, 2 or 4 bytes wide, sent least significant byte first. When they do not match, nothing happens on the peripheral lines.

Each wait phase is bounded by a parameterised cycle count. When that count runs out, the transfer is abandoned, the strobes are released and the timeout flag is set. The flag stays set until the host writes the status offset with bit 0 set. The host starts an access with a one-cycle request and is told of completion by a one-cycle done pulse that carries the read data.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset the control register reads 0xCC, the timeout flag is 0, busy is low, and the write, data-strobe and address-strobe lines are all high with the data driver off.
- R2: A host write to offset 2 stores the written byte with bits 7:6 forced to 1. A read of offset 2 returns the stored value.
- R3: A write to offset 3 or 4 runs a peripheral transfer only when control & 0x2F == 0x04. Otherwise it is dropped: no strobe, done on the next cycle, and the timeout flag is unchanged.
- R4: A read of offset 3 or 4 runs a transfer only when control & 0x2F == 0x24. Otherwise no strobe is driven and the read returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R5: A write byte cycle drives the byte with the driver enabled and pulls the write line low for one cycle before the strobe falls. Offset 3 uses the address strobe and offset 4 the data strobe, and the two are never low together. The strobe stays low until wait goes high, then rises, and the byte ends when wait returns low.
- R6: A read byte cycle keeps the write line high with the driver off, and captures the peripheral data in the cycle in which wait is seen high.
- R7: The data width code at offset 4 gives 1 byte for 0, 2 bytes for 1, and 4 bytes for 2 or 3. Bytes move least significant first, and read data is assembled little-endian with lanes above the width returned as zero. Offset 3 always moves one byte.
- R8: A wait phase that does not end within TIMEOUT_CYCLES cycles aborts the access. A strobe that is never answered stays low for exactly TIMEOUT_CYCLES cycles. The flag is set, no further bytes are moved, and read lanes within the width that were not received return ones.
- R9: A read of offset 1 returns bits 7:1 of the external status input with bit 0 replaced by the timeout flag.
- R10: A write to offset 1 with bit 0 set clears the timeout flag. A write with bit 0 clear leaves it as it is.
- R11: Busy is high for the whole of a running transfer, and done is a one-cycle pulse while busy is low. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle host access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset within the 8-byte window |
| size_i | input | 2 | Data width code for offset 4 (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| wdata_i | input | 8*DATA_BYTES | Host write data |
| busy_o | output | 1 | Peripheral transfer in progress |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | 8*DATA_BYTES | Read data, valid with done |
| ext_status_i | input | 8 | Status lines from the port |
| pd_o | output | 8 | Peripheral data out |
| pd_oe_o | output | 1 | Peripheral data driver enable |
| pd_i | input | 8 | Peripheral data in |
| nwrite_o | output | 1 | Write line, low for a write transfer |
| ndstb_o | output | 1 | Data strobe, active low |
| nastb_o | output | 1 | Address strobe, active low |
| wait_i | input | 1 | Peripheral wait/acknowledge |

## Verification
The hardest state to reach is a timeout in the release phase. There, the peripheral has answered the strobe but keeps wait high afterwards. The abort must then keep the byte already captured and fill the other lanes with ones. The bench peripheral model has three response modes: normal, never answering, and answering but never letting go. These reach both abort points on demand. A request is also injected while a dead-peripheral access holds the block busy, to show that it leaves the control register untouched.

// File: rtl/epp_engine_pkg.sv
package epp_engine_pkg;
   typedef enum logic [1:0] {
      XS_IDLE    = 2'd0,
      XS_SETUP   = 2'd1,
      XS_STROBE  = 2'd2,
      XS_RELEASE = 2'd3
   } xfer_state_e;

   localparam logic [2:0] OFS_STATUS   = 3'd1;
   localparam logic [2:0] OFS_CTRL     = 3'd2;
   localparam logic [2:0] OFS_EPP_ADDR = 3'd3;
   localparam logic [2:0] OFS_EPP_DATA = 3'd4;

   localparam logic [7:0] CTL_GATE_MASK  = 8'h2F;
   localparam logic [7:0] CTL_GATE_WR    = 8'h04;
   localparam logic [7:0] CTL_GATE_RD    = 8'h24;
   localparam logic [7:0] CTL_FIXED_ONES = 8'hC0;
   localparam logic [7:0] CTL_RESET_VAL  = 8'hCC;
endpackage

// File: rtl/epp_ctl_regs.sv
module epp_ctl_regs
   import epp_engine_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [7:0] ctl_wdata,
   input  logic       tmo_clr,
   input  logic       tmo_set,
   output logic [7:0] ctl_q,
   output logic       tmo_q,
   output logic       gate_wr_ok,
   output logic       gate_rd_ok
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET_VAL;
         tmo_q <= 1'b0;
      end else begin
         if (ctl_we) ctl_q <= ctl_wdata | CTL_FIXED_ONES;
         if (tmo_set)      tmo_q <= 1'b1;
         else if (tmo_clr) tmo_q <= 1'b0;
      end
   end

   assign gate_wr_ok = (ctl_q & CTL_GATE_MASK) == CTL_GATE_WR;
   assign gate_rd_ok = (ctl_q & CTL_GATE_MASK) == CTL_GATE_RD;
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
   parameter int unsigned LIMIT = 64,
   localparam int unsigned CW   = $clog2(LIMIT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic run_i,
   output logic expired_o
);
   if (LIMIT < 2) begin : g_bad_limit
      $error("epp_wait_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (run_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/epp_xfer_fsm.sv
module epp_xfer_fsm
   import epp_engine_pkg::*;
#(
   parameter int unsigned NBYTES = 4,
   localparam int unsigned IW    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
   localparam int unsigned DW    = 8 * NBYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          wr_i,
   input  logic          addr_cyc_i,
   input  logic [IW-1:0] last_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          wait_i,
   input  logic [7:0]    pd_i,
   input  logic          expired_i,
   output logic          busy_o,
   output logic          end_o,
   output logic          abort_o,
   output logic [DW-1:0] rdata_o,
   output logic          nwrite_o,
   output logic          ndstb_o,
   output logic          nastb_o,
   output logic [7:0]    pd_o,
   output logic          pd_oe_o,
   output logic          tmr_clr_o,
   output logic          tmr_run_o
);
   xfer_state_e   st;
   logic [IW-1:0] idx, last_q;
   logic          wr_q, adr_q;
   logic [DW-1:0] wbuf;
   logic [7:0]    wlane [NBYTES];
   logic          sample, step_done, accept;

   assign accept    = start_i && (st == XS_IDLE);
   assign sample    = (st == XS_STROBE) && wait_i;
   assign step_done = (st == XS_RELEASE) && !wait_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= XS_IDLE;
         idx    <= '0;
         last_q <= '0;
         wr_q   <= 1'b0;
         adr_q  <= 1'b0;
         wbuf   <= '0;
      end else begin
         unique case (st)
            XS_IDLE: if (accept) begin
               st     <= XS_SETUP;
               idx    <= '0;
               last_q <= last_i;
               wr_q   <= wr_i;
               adr_q  <= addr_cyc_i;
               wbuf   <= wdata_i;
            end
            XS_SETUP: st <= XS_STROBE;
            XS_STROBE: begin
               if (expired_i)   st <= XS_IDLE;
               else if (wait_i) st <= XS_RELEASE;
            end
            XS_RELEASE: begin
               if (expired_i) st <= XS_IDLE;
               else if (!wait_i) begin
                  if (idx == last_q) st <= XS_IDLE;
                  else begin
                     idx <= idx + 1'b1;
                     st  <= XS_SETUP;
                  end
               end
            end
            default: st <= XS_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                  lane_q <= 8'hFF;
         else if (accept)                             lane_q <= 8'hFF;
         else if (sample && !wr_q && idx == IW'(g))   lane_q <= pd_i;
      end
      assign rdata_o[8*g +: 8] = (IW'(g) <= last_q) ? lane_q : 8'h00;
      assign wlane[g]          = wbuf[8*g +: 8];
   end

   assign busy_o    = (st != XS_IDLE);
   assign abort_o   = expired_i;
   assign end_o     = (step_done && idx == last_q) || expired_i;
   assign nwrite_o  = !(busy_o && wr_q);
   assign pd_oe_o   = busy_o && wr_q;
   assign pd_o      = wlane[idx];
   assign ndstb_o   = !((st == XS_STROBE) && !adr_q);
   assign nastb_o   = !((st == XS_STROBE) && adr_q);
   assign tmr_clr_o = (st == XS_SETUP) || sample;
   assign tmr_run_o = ((st == XS_STROBE) && !wait_i) || ((st == XS_RELEASE) && wait_i);
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
   import epp_engine_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 64,
   parameter int unsigned DATA_BYTES     = 4,
   localparam int unsigned DW            = 8 * DATA_BYTES,
   localparam int unsigned IW            = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          wr_i,
   input  logic [2:0]    addr_i,
   input  logic [1:0]    size_i,
   input  logic [DW-1:0] wdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] rdata_o,
   input  logic [7:0]    ext_status_i,
   output logic [7:0]    pd_o,
   output logic          pd_oe_o,
   input  logic [7:0]    pd_i,
   output logic          nwrite_o,
   output logic          ndstb_o,
   output logic          nastb_o,
   input  logic          wait_i
);
   if (!(DATA_BYTES == 1 || DATA_BYTES == 2 || DATA_BYTES == 4)) begin : g_bad_width
      $error("epp_cycle_engine: DATA_BYTES must be 1, 2 or 4");
   end

   logic [7:0]    ctl_reg;
   logic          tmo_flag, gate_wr_ok, gate_rd_ok;
   logic          accept, is_epp, gate_ok, start, imm;
   logic          fsm_end, fsm_abort, tmr_clr, tmr_run, expired;
   logic [IW-1:0] sz_last, xfer_last;
   logic [DW-1:0] ones_mask, imm_rdata, fsm_rdata, rdata_q;
   logic          done_q;

   assign accept = req_i && !busy_o;
   assign is_epp = (addr_i == OFS_EPP_ADDR) || (addr_i == OFS_EPP_DATA);
   assign gate_ok = wr_i ? gate_wr_ok : gate_rd_ok;
   assign start  = accept && is_epp && gate_ok;
   assign imm    = accept && !start;

   always_comb begin
      unique case (size_i)
         2'd0:    sz_last = '0;
         2'd1:    sz_last = (DATA_BYTES > 1) ? IW'(1) : '0;
         default: sz_last = IW'(DATA_BYTES - 1);
      endcase
   end
   assign xfer_last = (addr_i == OFS_EPP_DATA) ? sz_last : '0;

   for (genvar g = 0; g < DATA_BYTES; g++) begin : g_mask
      assign ones_mask[8*g +: 8] = (IW'(g) <= xfer_last) ? 8'hFF : 8'h00;
   end

   always_comb begin
      imm_rdata = '0;
      if (!wr_i) begin
         unique case (addr_i)
            OFS_STATUS:                 imm_rdata[7:0] = {ext_status_i[7:1], tmo_flag};
            OFS_CTRL:                   imm_rdata[7:0] = ctl_reg;
            OFS_EPP_ADDR, OFS_EPP_DATA: imm_rdata      = ones_mask;
            default:                    imm_rdata[7:0] = 8'hFF;
         endcase
      end
   end

   epp_ctl_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (accept && wr_i && addr_i == OFS_CTRL),
      .ctl_wdata  (wdata_i[7:0]),
      .tmo_clr    (accept && wr_i && addr_i == OFS_STATUS && wdata_i[0]),
      .tmo_set    (fsm_abort),
      .ctl_q      (ctl_reg),
      .tmo_q      (tmo_flag),
      .gate_wr_ok (gate_wr_ok),
      .gate_rd_ok (gate_rd_ok)
   );

   epp_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (tmr_clr),
      .run_i     (tmr_run),
      .expired_o (expired)
   );

   epp_xfer_fsm #(.NBYTES(DATA_BYTES)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .wr_i       (wr_i),
      .addr_cyc_i (addr_i == OFS_EPP_ADDR),
      .last_i     (xfer_last),
      .wdata_i    (wdata_i),
      .wait_i     (wait_i),
      .pd_i       (pd_i),
      .expired_i  (expired),
      .busy_o     (busy_o),
      .end_o      (fsm_end),
      .abort_o    (fsm_abort),
      .rdata_o    (fsm_rdata),
      .nwrite_o   (nwrite_o),
      .ndstb_o    (ndstb_o),
      .nastb_o    (nastb_o),
      .pd_o       (pd_o),
      .pd_oe_o    (pd_oe_o),
      .tmr_clr_o  (tmr_clr),
      .tmr_run_o  (tmr_run)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= imm || fsm_end;
         if (imm)          rdata_q <= imm_rdata;
         else if (fsm_end) rdata_q <= pd_oe_o ? '0 : fsm_rdata;
      end
   end

   assign done_o  = done_q;
   assign rdata_o = rdata_q;
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk #(
   parameter int unsigned LIMIT = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_i,
   input logic       wr_i,
   input logic [2:0] addr_i,
   input logic       wbit0,
   input logic       busy_o,
   input logic       done_o,
   input logic       nwrite_o,
   input logic       ndstb_o,
   input logic       nastb_o,
   input logic [7:0] ctl_reg,
   input logic       tmo_flag
);
   logic [15:0] low_run;
   logic        stb_low;
   assign stb_low = !ndstb_o || !nastb_o;

   always_ff @(posedge clk) begin
      if (!rst_n)       low_run <= '0;
      else if (stb_low) low_run <= low_run + 1'b1;
      else              low_run <= '0;
   end

   // R5: only one strobe at a time
   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ndstb_o && !nastb_o));
   // R5: a strobe falls only after a setup cycle of the same transfer
   assert_strobe_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ndstb_o) |-> $past(busy_o));
   // R3 and R4: a strobe only under the matching control configuration
   assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_low |-> ((ctl_reg & 8'h2F) == (nwrite_o ? 8'h24 : 8'h04)));
   // R8: a strobe is never held past the timeout window
   assert_strobe_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= 16'(LIMIT));
   // R8: the flag rises only as an access completes
   assert_tmo_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> done_o);
   // R10: the flag falls only after a status write with bit 0 set
   assert_tmo_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmo_flag) |-> $past(req_i && wr_i && addr_i == 3'd1 && wbit0));
   // R11: done never overlaps a running transfer
   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o);
   // R2: control bits 7:6 stay set
   assert_ctl_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_reg[7:6] == 2'b11);
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.LIMIT(TIMEOUT_CYCLES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_i    (req_i),
   .wr_i     (wr_i),
   .addr_i   (addr_i),
   .wbit0    (wdata_i[0]),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .nwrite_o (nwrite_o),
   .ndstb_o  (ndstb_o),
   .nastb_o  (nastb_o),
   .ctl_reg  (ctl_reg),
   .tmo_flag (tmo_flag)
);

// File: tb/sim_epp_cycle_engine.sv
`timescale 1ns/1ps
module sim_epp_cycle_engine;
   localparam int TMO = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [1:0]  size = '0;
   logic [31:0] wdata = '0;
   logic        busy, done;
   logic [31:0] rdata;
   logic [7:0]  ext_status = 8'h5B;
   logic [7:0]  pd_o, pd_i;
   logic        pd_oe, nwrite, ndstb, nastb;
   logic        wait_r = 1'b0;

   int errors = 0;
   int checks = 0;

   // peripheral model state
   int          mode = 0;   // 0 normal, 1 never answers, 2 answers but holds wait high
   int          dly  = 2;
   int          lo_cnt = 0, hi_cnt = 0;
   logic [7:0]  rd_base = 8'h30;
   logic [7:0]  nstb = 8'h00;
   logic        prev_stb = 1'b0, prev_nw = 1'b1;
   logic [10:0] cap[$];     // {write line was low before strobe, driver on, address strobe, data}
   int          run = 0, last_run = 0;

   // host-visible model
   logic [7:0]  ctl_m = 8'hCC;
   logic        tmo_m = 1'b0;

   wire stb_w = !ndstb || !nastb;
   assign pd_i = rd_base + nstb;

   always #2 clk = ~clk;

   epp_cycle_engine #(.TIMEOUT_CYCLES(TMO), .DATA_BYTES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .size_i(size),
      .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
      .ext_status_i(ext_status), .pd_o(pd_o), .pd_oe_o(pd_oe), .pd_i(pd_i),
      .nwrite_o(nwrite), .ndstb_o(ndstb), .nastb_o(nastb), .wait_i(wait_r)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ones(input int nb);
      return (nb >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
   endfunction

   // peripheral handshake responder
   always @(posedge clk) begin
      if (!rst_n) begin
         wait_r <= 1'b0; lo_cnt <= 0; hi_cnt <= 0;
      end else if (stb_w) begin
         hi_cnt <= 0;
         if (mode != 1 && !wait_r) begin
            if (lo_cnt >= dly) wait_r <= 1'b1;
            else lo_cnt <= lo_cnt + 1;
         end
      end else begin
         lo_cnt <= 0;
         if (wait_r && mode != 2) begin
            if (hi_cnt >= dly) wait_r <= 1'b0;
            else hi_cnt <= hi_cnt + 1;
         end
      end
   end

   // capture of each strobe as the peripheral sees it
   always @(posedge clk) begin
      if (stb_w && !prev_stb) cap.push_back({!prev_nw, pd_oe, !nastb, pd_o});
      if (!stb_w && prev_stb) nstb <= nstb + 8'd1;
      prev_stb <= stb_w;
      prev_nw  <= nwrite;
   end

   // per-clock comparison of the idle lines against the model
   always @(negedge clk) begin
      if (rst_n) begin
         if (!busy)
            chk(ndstb && nastb && nwrite && !pd_oe, "R11 idle lines",
                {28'h0, ndstb, nastb, nwrite, pd_oe}, 32'hE);
         if (stb_w) run = run + 1;
         else begin
            if (run > 0) last_run = run;
            run = 0;
         end
      end
   end

   task automatic xact(input bit w, input logic [2:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag, output logic [31:0] rd);
      int q0 = cap.size();
      logic [7:0] n0 = nstb;
      int nb = (a != 3'd4) ? 1 : (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      bit epp = (a == 3'd3) || (a == 3'd4);
      bit gate = (ctl_m & 8'h2F) == (w ? 8'h04 : 8'h24);
      int moved = (epp && gate) ? ((mode == 0) ? nb : 1) : 0;
      logic [31:0] exp = 32'h0;
      int n = 0;
      @(negedge clk);
      req = 1'b1; wr = w; addr = a; size = sz; wdata = wd;
      @(negedge clk);
      req = 1'b0; wdata = '0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      if (n >= 2000) chk(1'b0, {tag, " watchdog"}, n, 0);
      rd = rdata;
      @(negedge clk);
      chk(!done, {tag, " R11 done one cycle"}, done, 0);
      repeat (6) @(negedge clk);
      // expected read value
      if (!w) begin
         case (a)
            3'd1: exp = {24'h0, ext_status[7:1], tmo_m};
            3'd2: exp = {24'h0, ctl_m};
            3'd3, 3'd4: begin
               exp = ones(nb);
               if (gate && mode == 0)
                  for (int k = 0; k < nb; k++) exp[8*k +: 8] = rd_base + n0 + 8'(k);
               else if (gate && mode == 2) exp[7:0] = rd_base + n0;
            end
            default: exp = 32'hFF;
         endcase
         chk(rd == exp, {tag, " read data"}, rd, exp);
      end
      chk(cap.size() - q0 == moved, {tag, " strobe count"}, cap.size() - q0, moved);
      for (int k = 0; k < moved && q0 + k < cap.size(); k++) begin
         logic [10:0] e = cap[q0 + k];
         chk(e[8] == (a == 3'd3), {tag, " strobe select R5"}, e[8], a == 3'd3);
         chk(e[10] == w && e[9] == w, {tag, " write line/driver R5 R6"}, e[10:9], {w, w});
         if (w) chk(e[7:0] == wd[8*k +: 8], {tag, " byte order R7"}, e[7:0], wd[8*k +: 8]);
      end
      // model update
      if (w && a == 3'd2) ctl_m = wd[7:0] | 8'hC0;
      if (w && a == 3'd1 && wd[0]) tmo_m = 1'b0;
      if (epp && gate && mode != 0) tmo_m = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && nwrite && ndstb && nastb && !pd_oe, "R1 lines after reset",
          {27'h0, busy, nwrite, ndstb, nastb, pd_oe}, 32'hE);
      xact(0, 3'd2, 0, 0, "R1 ctrl reset value", rd);
      xact(0, 3'd1, 0, 0, "R1 R9 status flag clear", rd);
      // R2 control write
      xact(1, 3'd2, 0, 32'h04, "R2 ctrl write", rd);
      xact(0, 3'd2, 0, 0, "R2 ctrl readback", rd);
      // R5 R7 write transfers
      xact(1, 3'd3, 2, 32'h3C, "R5 address write", rd);
      xact(1, 3'd4, 0, 32'hA5, "R5 data write 1B", rd);
      xact(1, 3'd4, 1, 32'hBEEF, "R7 data write 2B", rd);
      xact(1, 3'd4, 2, 32'h12345678, "R7 data write 4B", rd);
      xact(1, 3'd4, 3, 32'hCAFEF00D, "R7 data write code3", rd);
      // R3 write dropped under read config
      xact(1, 3'd2, 0, 32'h24, "R2 ctrl to read", rd);
      xact(1, 3'd4, 2, 32'h01020304, "R3 write gated", rd);
      // R6 R7 reads
      xact(0, 3'd3, 0, 0, "R6 address read", rd);
      xact(0, 3'd4, 0, 0, "R6 data read 1B", rd);
      xact(0, 3'd4, 1, 0, "R7 data read 2B", rd);
      xact(0, 3'd4, 2, 0, "R7 data read 4B", rd);
      // R4 read gated
      xact(1, 3'd2, 0, 32'h25, "R2 ctrl strobe bit", rd);
      xact(0, 3'd4, 2, 0, "R4 gated read 4B", rd);
      xact(0, 3'd4, 1, 0, "R4 gated read 2B", rd);
      xact(0, 3'd3, 0, 0, "R4 gated addr read", rd);
      xact(1, 3'd2, 0, 32'h06, "R2 ctrl autolf", rd);
      xact(1, 3'd3, 0, 32'h77, "R3 write gated autolf", rd);
      xact(0, 3'd1, 0, 0, "R3 flag unchanged", rd);
      // R8 timeout while the strobe is low
      xact(1, 3'd2, 0, 32'h04, "R2 ctrl write again", rd);
      mode = 1;
      xact(1, 3'd4, 2, 32'hDEADBEEF, "R8 dead write", rd);
      chk(last_run == TMO, "R8 strobe low length", last_run, TMO);
      mode = 0;
      xact(0, 3'd1, 0, 0, "R8 R9 status flag set", rd);
      // R10 clear rules
      xact(1, 3'd1, 0, 32'hFE, "R10 write bit0 clear", rd);
      xact(0, 3'd1, 0, 0, "R10 flag kept", rd);
      xact(1, 3'd1, 0, 32'h01, "R10 write bit0 set", rd);
      xact(0, 3'd1, 0, 0, "R10 flag cleared", rd);
      // R8 timeout after release
      xact(1, 3'd2, 0, 32'h24, "R2 ctrl to read again", rd);
      mode = 2;
      xact(0, 3'd4, 1, 0, "R8 hang read 2B", rd);
      mode = 0;
      repeat (8) @(negedge clk);
      xact(0, 3'd1, 0, 0, "R8 flag after hang", rd);
      xact(1, 3'd1, 0, 32'h01, "R10 clear again", rd);
      // R11 request while busy is ignored
      xact(1, 3'd2, 0, 32'h04, "R2 ctrl to write", rd);
      mode = 1;
      @(negedge clk);
      req = 1'b1; wr = 1'b1; addr = 3'd4; size = 2'd0; wdata = 32'h5A;
      @(negedge clk);
      req = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy, "R11 busy during transfer", busy, 1);
      req = 1'b1; wr = 1'b1; addr = 3'd2; wdata = 32'h24;
      @(negedge clk);
      req = 1'b0;
      begin
         int n = 0;
         while (!done && n < 2000) begin @(negedge clk); n++; end
      end
      tmo_m = 1'b1;
      mode = 0;
      repeat (6) @(negedge clk);
      xact(0, 3'd2, 0, 0, "R11 ctrl untouched", rd);
      xact(0, 3'd1, 0, 0, "R11 flag from abort", rd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule